// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Matrix

This block is a non-blocking N×N single-bit crosspoint. By default N is 32. Every output has its own N:1 selector, so any output can take any input, and one input can feed any number of outputs at the same time. Routing state is held in two register stages. A staging bank is written one output at a time. An active bank drives the selectors. The whole staged map goes live at one clock edge.

To reprogram the switch, software-side logic presents an output address and an input address and raises `load_en`. The input address is then written into the staging entry of that output. After all entries are staged, one `cfg_en` cycle copies every staging entry into the active bank at once. A separate preset strobe overwrites both banks with one of two fixed maps. The level of `cfg_en` in that cycle picks the map: every output from input 0, or output i from input i. If the load strobe is high during a preset, the block raises a one-cycle error flag. All control inputs are synchronous enables sampled on the rising edge of `clk`.

Top module: `xpt_matrix`

## Requirements
- R1: Each output bit equals the input bit that its active entry selects. The same input may be selected by several outputs at once. With the default OUT_REG=0 the path is combinational.
- R2: Output and input addresses are plain unsigned binary. Code k names port k, from 0 up to N-1.
- R3: A cycle with `load_en` high and `preset_req` low writes `in_addr` into the staging entry of output `out_addr` only. If `cfg_en` is low in that cycle, the routing seen at `data_out` does not change.
- R4: A cycle with `cfg_en` high and `preset_req` low copies all staging entries into the active bank. The new routing is visible at `data_out` right after that rising edge.
- R5: An output whose active entry is the same before and after a configure keeps carrying its input with no gap or glitch across the update edge.
- R6: A cycle with `preset_req` high and `cfg_en` low writes 0 into every staging and every active entry. This is broadcast from input 0.
- R7: A cycle with `preset_req` high and `cfg_en` high writes i into staging and active entry i for every output i. This is pass-through.
- R8: `proto_err` is 1 in the cycle after an edge where both `preset_req` and `load_en` were high. It is 0 after any other edge. The preset wins, and the load in that cycle is ignored.
- R9: When `load_en` and `cfg_en` are both high without a preset, the newly written entry goes into the active bank at that same edge, together with every other staged entry.
- R10: A configure after a preset with no loads in between leaves the routing unchanged.
- R11: While `rst_n` is low at a rising edge, both banks are cleared to 0 (broadcast from input 0) and `proto_err` is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| preset_req | input | 1 | Preset strobe; overwrites both banks with a fixed map |
| load_en | input | 1 | Stage `in_addr` into the entry of `out_addr` |
| cfg_en | input | 1 | Copy staging bank to active bank; map select during preset |
| out_addr | input | $clog2(N) | Output whose staging entry is written |
| in_addr | input | $clog2(N) | Input number to stage |
| data_in | input | N | Switched data inputs, bit i is input i |
| data_out | output | N | Switched data outputs, bit o is output o |
| proto_err | output | 1 | One-cycle flag: load strobe seen during a preset |

## Verification
On every cycle the assertions check the following. An edge with neither a configure nor a preset leaves the active bank unchanged. A configure makes the active bank equal to the staging bank. Both preset maps land in both banks. Entries that a configure does not change stay stable. The error flag follows the load-during-preset condition, and each output bit follows its selected input. The bench scenarios cover the rest, from the ports alone. They show that staged loads stay invisible until a configure, and that the preset maps survive a later configure with no loads. They also show that an unchanged output keeps a steady value across an update edge. Every scenario rebuilds the full routing map through a set of address-coded input patterns.

// File: rtl/xpt_pkg.sv
// Shared definitions for the crosspoint matrix.
// Assumes: nothing beyond IEEE 1800-2017.
package xpt_pkg;

    // Preset map chosen by a preset strobe
    typedef enum logic {
        PRESET_BCAST = 1'b0,   // every output from input 0
        PRESET_PASS  = 1'b1    // output i from input i
    } preset_e;

endpackage

// File: rtl/xpt_addr_decode.sv
// Output-address decoder: turns out_addr plus the load strobe into a
// one-hot write enable, one bit per output staging entry.
// Assumes: out_addr is plain binary; codes >= N produce no enable.
module xpt_addr_decode #(
    parameter int N  = 32,
    parameter int AW = 5
) (
    input  logic          load_en,
    input  logic [AW-1:0] out_addr,
    output logic [N-1:0]  wr_onehot
);

    // Compare the address against every output number
    generate
        for (genvar o = 0; o < N; o++) begin : g_dec
            assign wr_onehot[o] = load_en && (out_addr == AW'(o));
        end
    endgenerate

endmodule

// File: rtl/xpt_prog_bank.sv
// Staging bank: one AW-bit input number per output. A preset overwrites
// every entry, and otherwise an enabled entry takes in_addr. The
// next-state vector is exported so the active bank can take the
// freshly written value in the same cycle.
// Assumes: preset has priority over loads; rst_n clears to broadcast.
module xpt_prog_bank
    import xpt_pkg::*;
#(
    parameter int N  = 32,
    parameter int AW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            preset_req,
    input  preset_e         preset_mode,
    input  logic [N-1:0]    wr_onehot,
    input  logic [AW-1:0]   in_addr,
    output logic [N*AW-1:0] prog_q,
    output logic [N*AW-1:0] prog_d
);

    generate
        for (genvar o = 0; o < N; o++) begin : g_ent
            // Next value of entry o: preset map, new load, or hold
            always_comb begin
                if (preset_req) begin
                    prog_d[o*AW +: AW] = (preset_mode == PRESET_PASS) ? AW'(o) : '0;
                end else if (wr_onehot[o]) begin
                    prog_d[o*AW +: AW] = in_addr;
                end else begin
                    prog_d[o*AW +: AW] = prog_q[o*AW +: AW];
                end
            end

            // Register entry o
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prog_q[o*AW +: AW] <= '0;
                end else begin
                    prog_q[o*AW +: AW] <= prog_d[o*AW +: AW];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/xpt_active_bank.sv
// Active bank: the selections that drive the multiplexers. It takes the
// staging bank's next state as a whole on a configure or a preset, so
// the full map changes at a single edge.
// Assumes: prog_d already carries the preset map during a preset.
module xpt_active_bank #(
    parameter int N  = 32,
    parameter int AW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            preset_req,
    input  logic            cfg_en,
    input  logic [N*AW-1:0] prog_d,
    output logic [N*AW-1:0] act_q
);

    logic take;

    // Decide whether the active map is replaced this cycle
    always_comb take = preset_req || cfg_en;

    // Hold or replace the whole active map
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (take) begin
            act_q <= prog_d;
        end
    end

endmodule

// File: rtl/xpt_sel_mux.sv
// One output's N:1 selector. With OUT_REG=1 the selected bit is
// registered, and with OUT_REG=0 it passes straight through.
// Assumes: sel < N.
module xpt_sel_mux #(
    parameter int N       = 32,
    parameter int AW      = 5,
    parameter bit OUT_REG = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  data_in,
    input  logic [AW-1:0] sel,
    output logic          dout
);

    logic picked;

    // Pick the addressed input bit
    always_comb picked = data_in[sel];

    generate
        if (OUT_REG) begin : g_reg
            // Retime the selected bit
            always_ff @(posedge clk) begin
                if (!rst_n) dout <= 1'b0;
                else        dout <= picked;
            end
        end else begin : g_comb
            assign dout = picked;
        end
    endgenerate

endmodule

// File: rtl/xpt_matrix.sv
// Double-buffered N x N crosspoint. Loads fill a staging bank one
// output at a time, a configure makes the whole bank live at once, and
// a preset forces broadcast or pass-through into both banks.
// Assumes: all controls are synchronous to clk; N is a power of two.
module xpt_matrix
    import xpt_pkg::*;
#(
    parameter int N       = 32,
    parameter bit OUT_REG = 1'b0,
    localparam int AW     = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          preset_req,
    input  logic          load_en,
    input  logic          cfg_en,
    input  logic [AW-1:0] out_addr,
    input  logic [AW-1:0] in_addr,
    input  logic [N-1:0]  data_in,
    output logic [N-1:0]  data_out,
    output logic          proto_err
);

    logic [N-1:0]    wr_onehot;
    logic [N*AW-1:0] prog_q;
    logic [N*AW-1:0] prog_d;
    logic [N*AW-1:0] act_q;
    preset_e         preset_mode;

    // The configure level picks the preset map
    always_comb preset_mode = cfg_en ? PRESET_PASS : PRESET_BCAST;

    xpt_addr_decode #(.N(N), .AW(AW)) u_dec (
        .load_en   (load_en),
        .out_addr  (out_addr),
        .wr_onehot (wr_onehot)
    );

    xpt_prog_bank #(.N(N), .AW(AW)) u_prog (
        .clk         (clk),
        .rst_n       (rst_n),
        .preset_req  (preset_req),
        .preset_mode (preset_mode),
        .wr_onehot   (wr_onehot),
        .in_addr     (in_addr),
        .prog_q      (prog_q),
        .prog_d      (prog_d)
    );

    xpt_active_bank #(.N(N), .AW(AW)) u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .preset_req (preset_req),
        .cfg_en     (cfg_en),
        .prog_d     (prog_d),
        .act_q      (act_q)
    );

    generate
        for (genvar o = 0; o < N; o++) begin : g_col
            xpt_sel_mux #(.N(N), .AW(AW), .OUT_REG(OUT_REG)) u_mux (
                .clk     (clk),
                .rst_n   (rst_n),
                .data_in (data_in),
                .sel     (act_q[o*AW +: AW]),
                .dout    (data_out[o])
            );
        end
    endgenerate

    // Flag a load strobe seen during a preset
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= preset_req && load_en;
    end

endmodule

// File: rtl/xpt_matrix_chk.sv
// Checker for xpt_matrix, attached by bind. It watches the ports and
// the two register banks.
// Assumes: the same N and OUT_REG as the bound instance.
module xpt_matrix_chk #(
    parameter int N       = 32,
    parameter bit OUT_REG = 1'b0,
    parameter int AW      = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            preset_req,
    input logic            load_en,
    input logic            cfg_en,
    input logic [AW-1:0]   out_addr,
    input logic [AW-1:0]   in_addr,
    input logic [N-1:0]    data_in,
    input logic [N-1:0]    data_out,
    input logic            proto_err,
    input logic [N*AW-1:0] prog_q,
    input logic [N*AW-1:0] act_q
);

    logic [N*AW-1:0] ident_map;
    logic [AW-1:0]   last_oa;
    logic [AW-1:0]   last_ia;

    generate
        for (genvar o = 0; o < N; o++) begin : g_id
            assign ident_map[o*AW +: AW] = AW'(o);
        end
    endgenerate

    // Remember the last addresses for the same-cycle load check
    always_ff @(posedge clk) begin
        last_oa <= out_addr;
        last_ia <= in_addr;
    end

    assert_hold_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && !preset_req) |=> $stable(act_q));

    assert_copy_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !preset_req && !load_en) |=> (act_q == $past(prog_q)));

    assert_bcast_preset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_req && !cfg_en) |=> (act_q == '0 && prog_q == '0));

    assert_pass_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_req && cfg_en) |=> (act_q == ident_map && prog_q == ident_map));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_req && load_en) |=> proto_err);

    assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(preset_req && load_en) |=> !proto_err);

    assert_same_cycle_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && load_en && !preset_req) |=> (act_q[last_oa*AW +: AW] == last_ia));

    generate
        for (genvar o = 0; o < N; o++) begin : g_prop
            assert_unchanged_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!preset_req && prog_q[o*AW +: AW] == act_q[o*AW +: AW]
                 && !(load_en && out_addr == AW'(o)))
                |=> $stable(act_q[o*AW +: AW]));

            if (!OUT_REG) begin : g_route
                assert_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
                    data_out[o] == data_in[act_q[o*AW +: AW]]);
            end
        end
    endgenerate

endmodule

bind xpt_matrix xpt_matrix_chk #(.N(N), .OUT_REG(OUT_REG), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset_req (preset_req),
    .load_en    (load_en),
    .cfg_en     (cfg_en),
    .out_addr   (out_addr),
    .in_addr    (in_addr),
    .data_in    (data_in),
    .data_out   (data_out),
    .proto_err  (proto_err),
    .prog_q     (prog_q),
    .act_q      (act_q)
);

// File: tb/sim_xpt_matrix.sv
// Directed bench for xpt_matrix. A reference model keeps the staging and
// active maps. The real routing is rebuilt from the ports by driving
// address-coded input patterns.
module sim_xpt_matrix;

    localparam int N  = 32;
    localparam int AW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          preset_req;
    logic          load_en;
    logic          cfg_en;
    logic [AW-1:0] out_addr;
    logic [AW-1:0] in_addr;
    logic [N-1:0]  data_in;
    logic [N-1:0]  data_out;
    logic          proto_err;

    int checks = 0;
    int errors = 0;
    int ref_prog [N];
    int ref_act  [N];

    always #5 clk = ~clk;

    xpt_matrix #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .preset_req(preset_req), .load_en(load_en),
        .cfg_en(cfg_en), .out_addr(out_addr), .in_addr(in_addr),
        .data_in(data_in), .data_out(data_out), .proto_err(proto_err)
    );

    // Rebuild the live map from the ports and compare with ref_act
    task automatic check_map(input string req);
        int got [N];
        bit bad = 0;
        for (int o = 0; o < N; o++) got[o] = 0;
        for (int k = 0; k < AW; k++) begin
            for (int i = 0; i < N; i++) data_in[i] = ((i >> k) & 1) != 0;
            #1;
            for (int o = 0; o < N; o++) if (data_out[o]) got[o] |= (1 << k);
        end
        checks++;
        for (int o = 0; o < N; o++) begin
            if (got[o] != ref_act[o]) begin
                $display("FAIL %s: output %0d routed from %0d, expected %0d", req, o, got[o], ref_act[o]);
                bad = 1;
            end
        end
        if (bad) errors++;
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b, expected %b", req, act, exp);
        end
    endtask

    // One clock with the given controls, released 1 ns after the edge
    task automatic step(input logic pr, input logic ld, input logic cf,
                        input int oa, input int ia);
        @(negedge clk);
        preset_req = pr; load_en = ld; cfg_en = cf;
        out_addr = AW'(oa); in_addr = AW'(ia);
        @(posedge clk); #1;
        preset_req = 0; load_en = 0; cfg_en = 0;
        if (pr) for (int o = 0; o < N; o++) begin
            ref_prog[o] = cf ? o : 0; ref_act[o] = ref_prog[o];
        end else begin
            if (ld) ref_prog[oa] = ia;
            if (cf) for (int o = 0; o < N; o++) ref_act[o] = ref_prog[o];
        end
    endtask

    task automatic t_reset;
        rst_n = 0; preset_req = 0; load_en = 0; cfg_en = 0;
        out_addr = '0; in_addr = '0; data_in = '0;
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        for (int o = 0; o < N; o++) begin ref_prog[o] = 0; ref_act[o] = 0; end
        check_map("R11 reset broadcast");
        check_bit("R11 proto_err after reset", proto_err, 1'b0);
    endtask

    task automatic t_stage_only;
        step(0, 1, 0, 0, N-1);
        step(0, 1, 0, N-1, 0);
        step(0, 1, 0, 5, 17);
        check_map("R3 loads not live before configure");
    endtask

    task automatic t_configure;
        for (int o = 0; o < N; o++) step(0, 1, 0, o, (o * 7 + 3) % N);
        step(0, 0, 1, 0, 0);
        check_map("R4 R2 full map after configure");
        step(0, 1, 0, 9, 4);
        step(0, 1, 0, 10, 4);
        step(0, 1, 0, 11, 4);
        step(0, 0, 1, 0, 0);
        check_map("R1 fanout of one input");
    endtask

    task automatic t_unchanged;
        logic before_b, after_b;
        int src = ref_act[20];
        step(0, 1, 0, 2, (ref_act[2] + 1) % N);
        @(negedge clk);
        data_in = '0; data_in[src] = 1'b1;
        cfg_en = 1;
        #4; before_b = data_out[20];
        @(posedge clk); #1; after_b = data_out[20];
        cfg_en = 0;
        for (int o = 0; o < N; o++) ref_act[o] = ref_prog[o];
        check_bit("R5 unchanged output before edge", before_b, 1'b1);
        check_bit("R5 unchanged output after edge", after_b, 1'b1);
        check_map("R5 map after partial change");
    endtask

    task automatic t_presets;
        step(1, 0, 0, 0, 0);
        check_map("R6 broadcast preset");
        step(0, 0, 1, 0, 0);
        check_map("R10 configure after broadcast preset");
        step(1, 0, 1, 0, 0);
        check_map("R7 pass-through preset");
        step(0, 0, 1, 0, 0);
        check_map("R10 configure after pass-through preset");
    endtask

    task automatic t_proto_err;
        @(negedge clk);
        preset_req = 1; load_en = 1; cfg_en = 0; out_addr = AW'(3); in_addr = AW'(12);
        @(posedge clk); #1;
        preset_req = 0; load_en = 0;
        for (int o = 0; o < N; o++) begin ref_prog[o] = 0; ref_act[o] = 0; end
        check_bit("R8 error flag set", proto_err, 1'b1);
        step(0, 0, 1, 0, 0);
        check_bit("R8 error flag cleared", proto_err, 1'b0);
        check_map("R8 load during preset ignored");
    endtask

    task automatic t_same_cycle;
        step(0, 1, 0, 6, 25);
        step(0, 1, 1, 7, 30);
        check_map("R9 load and configure together");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_stage_only();
        t_configure();
        t_unchanged();
        t_presets();
        t_proto_err();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule